// File: doc/BRIEF.md
# Debug Back-Channel Mailbox

This block gives a running processor and an external debug probe a two-way word channel without halting the core. It holds one 32-bit word per direction. The processor writes outbound words and reads inbound words through a small register interface in its own clock domain. The debug probe reaches the same pair through a 34-bit scan register. The scan register is clocked by the serial test clock and driven by capture, shift and update strobes from an external test-port controller.

Each direction has a full flag. The writer's side sets the flag. The reader's side clears it. Every set or clear event crosses between the two clock domains as a toggle through a two-stage synchronizer. While a word is pending, a new write from the same side is refused: the stored word is kept and a sticky error bit is raised. The processor sees a status word and, when enabled, an interrupt that stays high while an inbound word waits. The debug side sees both flags in every captured scan word.

Each side runs two small state machines.

Processor side:
- Outbound FSM: state `OB_EMPTY` moves to `OB_FULL` on an accepted data write. `OB_FULL` returns to `OB_EMPTY` when the debug side's read acknowledge arrives.
- Inbound FSM: state `IB_EMPTY` moves to `IB_AVAIL` when the debug side's write request arrives. `IB_AVAIL` returns to `IB_EMPTY` on a processor data read.

Debug side:
- View FSM: state `VW_EMPTY` moves to `VW_FULL` when the processor's write request arrives. `VW_FULL` returns to `VW_EMPTY` on a capture.
- Receive FSM: state `RX_OPEN` moves to `RX_HELD` on an update that carries the write flag. `RX_HELD` returns to `RX_OPEN` when the processor's read acknowledge arrives.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset the status word reads 0, `cpu_irq` and `dbg_overrun` are 0, and a first capture returns an all-zero scan word.
- R2: A processor write to address 0 while status bit 1 is clear stores the word, and status bit 1 (outbound full) reads 1 on the next clock cycle.
- R3: A processor write to address 0 while status bit 1 is set is refused. The stored word is unchanged and status bit 2 (write refused) is set. Bit 2 stays set until a status read (address 1), which clears it after returning it.
- R4: A capture loads scan bits [31:0] with the outbound word, bit 32 with the debug-side outbound-full flag and bit 33 with the inbound-full flag. Each shift moves the register one place toward bit 0: `dbg_tdo` shows bit 0, and `dbg_tdi` enters at bit 33, so the word goes out least significant bit first.
- R5: A capture that sees bit 32 set consumes the outbound word. Status bit 1 clears after the acknowledge crosses into the processor clock domain, and the next capture shows bit 32 clear.
- R6: An update whose shifted-in bit 33 is 1, while the inbound word is empty, loads bits [31:0] as the inbound word. After crossing, status bit 0 (inbound available) reads 1 and `cpu_irq` is 1.
- R7: An update whose bit 33 is 1, while the inbound word is still full, is dropped: the inbound word keeps its first value and `dbg_overrun` goes to 1 and stays there until debug reset.
- R8: A processor read of address 0 while status bit 0 is set returns the inbound word and clears status bit 0 and `cpu_irq` on the next cycle. After crossing, captured bit 33 is clear.
- R9: An update whose bit 33 is 0 is a poll and changes neither the inbound word nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Processor-domain reset, active low |
| cpu_sel | input | 1 | Register access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 1 | 0 = data word, 1 = status word |
| cpu_wdata | input | 32 | Outbound word to write |
| cpu_rdata | output | 32 | Inbound word (address 0) or status (address 1), combinational |
| cpu_irq | output | 1 | High while an inbound word waits (when enabled) |
| tck | input | 1 | Serial test clock |
| trst_n | input | 1 | Debug-domain reset, active low |
| dbg_sel | input | 1 | Mailbox scan register selected by the test-port controller |
| dbg_capture | input | 1 | Capture strobe |
| dbg_shift | input | 1 | Shift strobe |
| dbg_update | input | 1 | Update strobe |
| dbg_tdi | input | 1 | Serial data in |
| dbg_tdo | output | 1 | Serial data out (scan bit 0) |
| dbg_overrun | output | 1 | Sticky: an inbound write was dropped |

## Verification
Processor-side results land one clock edge after the access: status bits 1 and 2 after a write, and bit 0 and the interrupt clearing after a read. The bench therefore reads status on the very next access. A flag that crosses domains needs about three edges of the receiving clock. The bench waits at least five test clocks before a capture that must see a processor action, and at least ten processor clocks before a status read that must see a debug action. It then compares the exact word. Scan bits are sampled on the falling test clock before each shifting edge, so that bit i of the captured word is the i-th bit out.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    // processor register map
    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // status word bit positions
    localparam int ST_IB_AVAIL = 0;
    localparam int ST_OB_FULL  = 1;
    localparam int ST_WR_ERR   = 2;

    typedef enum logic [0:0] {OB_EMPTY, OB_FULL}  ob_state_t;
    typedef enum logic [0:0] {IB_EMPTY, IB_AVAIL} ib_state_t;
    typedef enum logic [0:0] {VW_EMPTY, VW_FULL}  view_state_t;
    typedef enum logic [0:0] {RX_OPEN,  RX_HELD}  rx_state_t;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_cpu_port.sv
`timescale 1ns/1ps
module mbx_cpu_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit IRQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_irq,
    input  logic              ob_ack_s,
    input  logic              ib_req_s,
    input  logic [DATA_W-1:0] ib_word,
    output logic [DATA_W-1:0] ob_word,
    output logic              ob_req_tgl,
    output logic              ib_ack_tgl
);
    ob_state_t ob_state, ob_next;
    ib_state_t ib_state, ib_next;

    logic wr_data, rd_data, rd_stat;
    logic ack_seen, req_seen, ack_evt, req_evt;
    logic err_sticky;
    logic [DATA_W-1:0] status;

    assign wr_data = cpu_sel &  cpu_we & (cpu_addr == ADDR_DATA);
    assign rd_data = cpu_sel & ~cpu_we & (cpu_addr == ADDR_DATA);
    assign rd_stat = cpu_sel & ~cpu_we & (cpu_addr == ADDR_STAT);
    assign ack_evt = ob_ack_s ^ ack_seen;
    assign req_evt = ib_req_s ^ req_seen;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_state <= OB_EMPTY;
            ib_state <= IB_EMPTY;
            ack_seen <= 1'b0;
            req_seen <= 1'b0;
        end else begin
            ob_state <= ob_next;
            ib_state <= ib_next;
            ack_seen <= ob_ack_s;
            req_seen <= ib_req_s;
        end
    end

    // next state
    always_comb begin
        ob_next = ob_state;
        unique case (ob_state)
            OB_EMPTY: if (wr_data) ob_next = OB_FULL;
            OB_FULL:  if (ack_evt) ob_next = OB_EMPTY;
        endcase
        ib_next = ib_state;
        unique case (ib_state)
            IB_EMPTY: if (req_evt) ib_next = IB_AVAIL;
            IB_AVAIL: if (rd_data) ib_next = IB_EMPTY;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_word    <= '0;
            ob_req_tgl <= 1'b0;
            ib_ack_tgl <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            if (ob_state == OB_EMPTY && wr_data) begin
                ob_word    <= cpu_wdata;
                ob_req_tgl <= ~ob_req_tgl;
            end
            if (ib_state == IB_AVAIL && rd_data)
                ib_ack_tgl <= ~ib_ack_tgl;
            if (ob_state == OB_FULL && wr_data)
                err_sticky <= 1'b1;
            else if (rd_stat)
                err_sticky <= 1'b0;
        end
    end

    always_comb begin
        status              = '0;
        status[ST_IB_AVAIL] = (ib_state == IB_AVAIL);
        status[ST_OB_FULL]  = (ob_state == OB_FULL);
        status[ST_WR_ERR]   = err_sticky;
        cpu_rdata = (cpu_addr == ADDR_STAT) ? status : ib_word;
    end

    generate
        if (IRQ_EN) begin : g_irq
            assign cpu_irq = (ib_state == IB_AVAIL);
        end else begin : g_no_irq
            assign cpu_irq = 1'b0;
        end
    endgenerate

    // R2
    ob_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ob_state == OB_EMPTY) |=> (ob_word == $past(cpu_wdata) && ob_state == OB_FULL));
    // R3
    ob_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && ob_state == OB_FULL) |=> ($stable(ob_word) && err_sticky));
    // R8
    ib_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && ib_state == IB_AVAIL) |=> (ib_state == IB_EMPTY));
    // R5
    ob_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_state == OB_FULL && !ack_evt) |=> (ob_state == OB_FULL));
endmodule

// File: rtl/mbx_dbg_port.sv
`timescale 1ns/1ps
module mbx_dbg_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              dbg_sel,
    input  logic              dbg_capture,
    input  logic              dbg_shift,
    input  logic              dbg_update,
    input  logic              dbg_tdi,
    output logic              dbg_tdo,
    output logic              dbg_overrun,
    input  logic [DATA_W-1:0] ob_word,
    input  logic              ob_req_s,
    input  logic              ib_ack_s,
    output logic [DATA_W-1:0] ib_word,
    output logic              ib_req_tgl,
    output logic              ob_ack_tgl
);
    localparam int SCAN_W = DATA_W + 2;
    localparam int VLD_B  = DATA_W;
    localparam int WR_B   = DATA_W + 1;

    view_state_t view_state, view_next;
    rx_state_t   rx_state, rx_next;

    logic [SCAN_W-1:0] sr;
    logic cap, sh, upd_wr;
    logic req_seen, ack_seen, req_evt, ack_evt;

    assign cap     = dbg_sel & dbg_capture;
    assign sh      = dbg_sel & dbg_shift;
    assign upd_wr  = dbg_sel & dbg_update & sr[WR_B];
    assign req_evt = ob_req_s ^ req_seen;
    assign ack_evt = ib_ack_s ^ ack_seen;
    assign dbg_tdo = sr[0];

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            view_state <= VW_EMPTY;
            rx_state   <= RX_OPEN;
            req_seen   <= 1'b0;
            ack_seen   <= 1'b0;
        end else begin
            view_state <= view_next;
            rx_state   <= rx_next;
            req_seen   <= ob_req_s;
            ack_seen   <= ib_ack_s;
        end
    end

    // next state
    always_comb begin
        view_next = view_state;
        unique case (view_state)
            VW_EMPTY: if (req_evt) view_next = VW_FULL;
            VW_FULL:  if (cap)     view_next = VW_EMPTY;
        endcase
        rx_next = rx_state;
        unique case (rx_state)
            RX_OPEN: if (upd_wr)  rx_next = RX_HELD;
            RX_HELD: if (ack_evt) rx_next = RX_OPEN;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr          <= '0;
            ib_word     <= '0;
            ib_req_tgl  <= 1'b0;
            ob_ack_tgl  <= 1'b0;
            dbg_overrun <= 1'b0;
        end else begin
            if (cap)
                sr <= {rx_state == RX_HELD, view_state == VW_FULL, ob_word};
            else if (sh)
                sr <= {dbg_tdi, sr[SCAN_W-1:1]};
            if (cap && view_state == VW_FULL)
                ob_ack_tgl <= ~ob_ack_tgl;
            if (upd_wr && rx_state == RX_OPEN) begin
                ib_word    <= sr[DATA_W-1:0];
                ib_req_tgl <= ~ib_req_tgl;
            end
            if (upd_wr && rx_state == RX_HELD)
                dbg_overrun <= 1'b1;
        end
    end

    // R7
    rx_drop_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (upd_wr && rx_state == RX_HELD) |=> ($stable(ib_word) && dbg_overrun));
    // R7
    overrun_sticky_chk: assert property (@(posedge tck) disable iff (!trst_n)
        dbg_overrun |=> dbg_overrun);
    // R5
    view_consume_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (cap && view_state == VW_FULL) |=> (view_state == VW_EMPTY));
    // R4
    shift_dir_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sh && !cap) |=> (sr[SCAN_W-2:0] == $past(sr[SCAN_W-1:1]) && sr[SCAN_W-1] == $past(dbg_tdi)));
    // R9
    poll_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (dbg_sel && dbg_update && !sr[WR_B]) |=> $stable(ib_word));
endmodule

// File: rtl/dbg_mailbox.sv
`timescale 1ns/1ps
module dbg_mailbox #(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit IRQ_EN      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_irq,
    input  logic              tck,
    input  logic              trst_n,
    input  logic              dbg_sel,
    input  logic              dbg_capture,
    input  logic              dbg_shift,
    input  logic              dbg_update,
    input  logic              dbg_tdi,
    output logic              dbg_tdo,
    output logic              dbg_overrun
);
    logic [DATA_W-1:0] ob_word, ib_word;
    logic ob_req_tgl, ob_req_s, ob_ack_tgl, ob_ack_s;
    logic ib_req_tgl, ib_req_s, ib_ack_tgl, ib_ack_s;

    mbx_cpu_port #(.DATA_W(DATA_W), .IRQ_EN(IRQ_EN)) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_irq(cpu_irq),
        .ob_ack_s(ob_ack_s), .ib_req_s(ib_req_s), .ib_word(ib_word),
        .ob_word(ob_word), .ob_req_tgl(ob_req_tgl), .ib_ack_tgl(ib_ack_tgl)
    );

    mbx_dbg_port #(.DATA_W(DATA_W)) u_dbg (
        .tck(tck), .trst_n(trst_n),
        .dbg_sel(dbg_sel), .dbg_capture(dbg_capture), .dbg_shift(dbg_shift),
        .dbg_update(dbg_update), .dbg_tdi(dbg_tdi), .dbg_tdo(dbg_tdo),
        .dbg_overrun(dbg_overrun),
        .ob_word(ob_word), .ob_req_s(ob_req_s), .ib_ack_s(ib_ack_s),
        .ib_word(ib_word), .ib_req_tgl(ib_req_tgl), .ob_ack_tgl(ob_ack_tgl)
    );

    // processor to debug events
    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ob_req (
        .clk(tck), .rst_n(trst_n), .d(ob_req_tgl), .q(ob_req_s));
    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ib_ack (
        .clk(tck), .rst_n(trst_n), .d(ib_ack_tgl), .q(ib_ack_s));
    // debug to processor events
    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ob_ack (
        .clk(clk), .rst_n(rst_n), .d(ob_ack_tgl), .q(ob_ack_s));
    mbx_sync #(.STAGES(SYNC_STAGES)) u_sync_ib_req (
        .clk(clk), .rst_n(rst_n), .d(ib_req_tgl), .q(ib_req_s));
endmodule

// File: tb/dbg_mailbox_test.sv
`timescale 1ns/1ps
module dbg_mailbox_test;
    logic        clk = 1'b0, tck = 1'b0;
    logic        rst_n = 1'b0, trst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0, cpu_addr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_irq;
    logic        dbg_sel = 1'b0, dbg_capture = 1'b0, dbg_shift = 1'b0;
    logic        dbg_update = 1'b0, dbg_tdi = 1'b0;
    logic        dbg_tdo, dbg_overrun;
    int          n_chk = 0, n_fail = 0;

    always #2  clk = ~clk;   // 250 MHz
    always #10 tck = ~tck;

    dbg_mailbox uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_irq(cpu_irq), .tck(tck), .trst_n(trst_n), .dbg_sel(dbg_sel),
        .dbg_capture(dbg_capture), .dbg_shift(dbg_shift), .dbg_update(dbg_update),
        .dbg_tdi(dbg_tdi), .dbg_tdo(dbg_tdo), .dbg_overrun(dbg_overrun)
    );

    function automatic logic [31:0] exp_stat(input bit avail, input bit full, input bit err);
        return {29'd0, err, full, avail};
    endfunction

    function automatic logic [33:0] wr_frame(input logic [31:0] d);
        return {1'b1, 1'b0, d};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tck_wait(input int n);
        repeat (n) @(negedge tck);
    endtask

    task automatic cpu_wr(input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = 1'b0; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic scan(input logic [33:0] din, output logic [33:0] dout);
        @(negedge tck);
        dbg_sel = 1'b1; dbg_capture = 1'b1;
        @(negedge tck);
        dbg_capture = 1'b0; dbg_shift = 1'b1;
        for (int i = 0; i < 34; i++) begin
            dbg_tdi = din[i];
            #1 dout[i] = dbg_tdo;
            @(negedge tck);
        end
        dbg_shift = 1'b0; dbg_update = 1'b1;
        @(negedge tck);
        dbg_update = 1'b0; dbg_sel = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rd, a, b, c, d, last_ob;
        logic [33:0] so;
        void'($urandom(32'h0B5E_ED01));

        clk_wait(5);
        rst_n = 1'b1; trst_n = 1'b1;
        tck_wait(2);

        // R1 reset state
        cpu_rd(1'b1, rd);
        chk("R1 status", rd, exp_stat(0, 0, 0));
        chk("R1 irq", cpu_irq, 0);
        chk("R1 overrun", dbg_overrun, 0);
        scan(34'd0, so);
        chk("R1 scan", so, 34'd0);

        // R2/R3 outbound, refused second write
        a = 32'hA5C3_1E07; b = 32'h0F0F_1234;
        cpu_wr(a);
        cpu_rd(1'b1, rd);
        chk("R2 status full", rd, exp_stat(0, 1, 0));
        cpu_wr(b);
        cpu_rd(1'b1, rd);
        chk("R3 refused flag", rd, exp_stat(0, 1, 1));
        cpu_rd(1'b1, rd);
        chk("R3 flag cleared by read", rd, exp_stat(0, 1, 0));
        tck_wait(5);
        scan(34'd0, so);
        chk("R4 R3 captured word lsb first", so[31:0], a);
        chk("R4 flags", so[33:32], 2'b01);
        clk_wait(20);
        cpu_rd(1'b1, rd);
        chk("R5 status after consume", rd, exp_stat(0, 0, 0));
        scan(34'd0, so);
        chk("R5 second capture empty", so[33:32], 2'b00);
        last_ob = a;

        // R6/R7/R8 inbound with overrun
        c = 32'h8000_0001; d = 32'h7E57_DA7A;
        tck_wait(2);
        scan(wr_frame(c), so);
        clk_wait(10);
        cpu_rd(1'b1, rd);
        chk("R6 status avail", rd, exp_stat(1, 0, 0));
        chk("R6 irq", cpu_irq, 1);
        chk("R6 no overrun yet", dbg_overrun, 0);
        scan(wr_frame(d), so);
        chk("R4 inbound flag captured", so[33:32], 2'b10);
        chk("R7 overrun set", dbg_overrun, 1);
        cpu_rd(1'b0, rd);
        chk("R7 R8 first word kept", rd, c);
        cpu_rd(1'b1, rd);
        chk("R8 status cleared", rd, exp_stat(0, 0, 0));
        chk("R8 irq cleared", cpu_irq, 0);
        tck_wait(5);
        scan(34'd0, so);
        chk("R8 debug flag cleared", so[33:32], 2'b00);
        chk("R7 overrun sticky", dbg_overrun, 1);

        // R9 poll
        scan({2'b00, 32'hDEAD_BEEF}, so);
        clk_wait(10);
        cpu_rd(1'b1, rd);
        chk("R9 poll leaves status", rd, exp_stat(0, 0, 0));
        cpu_rd(1'b0, rd);
        chk("R9 poll leaves inbound word", rd, c);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int unsigned kind;
            logic [31:0] r;
            kind = $urandom_range(0, 2);
            r = $urandom();
            if (kind == 0) begin
                cpu_wr(r);
                cpu_rd(1'b1, rd);
                chk("R2 random status", rd, exp_stat(0, 1, 0));
                tck_wait(5);
                scan(34'd0, so);
                chk("R4 random capture", so, {2'b01, r});
                clk_wait(20);
                cpu_rd(1'b1, rd);
                chk("R5 random release", rd, exp_stat(0, 0, 0));
                last_ob = r;
            end else if (kind == 1) begin
                scan(wr_frame(r), so);
                chk("R4 random idle capture", so, {2'b00, last_ob});
                clk_wait(10);
                cpu_rd(1'b1, rd);
                chk("R6 random avail", rd, exp_stat(1, 0, 0));
                cpu_rd(1'b0, rd);
                chk("R8 random read", rd, r);
                c = r;
                tck_wait(5);
            end else begin
                scan({2'b00, r}, so);
                clk_wait(10);
                cpu_rd(1'b1, rd);
                chk("R9 random poll", rd, exp_stat(0, 0, 0));
                cpu_rd(1'b0, rd);
                chk("R9 random word kept", rd, c);
            end
        end

        summary();
        $finish;
    end
endmodule